// File: doc/BRIEF.md
# Eight-Input Nested Priority Interrupt Controller

This block collects eight interrupt request lines and raises one interrupt line to a processor. Each request line can be blocked on its own by a mask bit. When the processor acknowledges, the block returns an 8-bit vector on its read data port. The upper five bits of that vector are a programmable base. The lower three bits are the index of the winning line. Line 0 has the highest priority and line 7 the lowest.

Priority is fully nested. Once a line has been acknowledged it is in service. While it is in service, it holds back its own level and every lower level until software writes an end-of-interrupt command. Request lines are edge-triggered. A rising edge latches a pending request, and that request stays pending until it is acknowledged.

Software reaches the block through a small register port made of a select, a read strobe, a write strobe and one address bit.

Top module: `prio_intc`

## Requirements
- R1: After reset the interrupt output is low and the base is 0. No request is pending or in service, and the mask is all ones, so a read at address 1 returns 0xFF.
- R2: A write at address 1 loads the mask and a read at address 1 returns it. A line whose mask bit is 1 never raises the interrupt output.
- R3: Among eligible requests the lowest index wins. The vector is the base in bits 7:3 and the winner's index in bits 2:0.
- R4: While `ack` is high, `rdata` shows the winner's vector. At the clock edge that ends the `ack` cycle, the winner's pending bit clears and its in-service bit sets.
- R5: The interrupt output is high exactly when some pending, unmasked request has a lower index than every in-service line.
- R6: A write at address 0 with bit 0 set is an end-of-interrupt command. It clears the lowest-index in-service bit and leaves the base unchanged.
- R7: A rising edge on a request line sets its pending bit at the next clock edge. Holding the line high does not set the bit again after it is acknowledged. A falling edge does not clear the bit.
- R8: A write at address 0 with bit 0 clear loads bits 7:3 into the base.
- R9: An acknowledge with no eligible request returns the base with index 7 and changes no state.
- R10: With `ack` low, `rdata` is 0 unless a read at address 1 is in progress. This includes reads at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines, rising-edge sensitive |
| ack | input | 1 | Interrupt acknowledge from the processor, one cycle per acknowledge |
| sel | input | 1 | Register port select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or vector |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
A stale in-service bit shows up on the next cycle as `int_out` held low while an unmasked request is pending. A lost pending bit shows up the same way. A wrong winner shows up as a wrong low field in the vector during the `ack` cycle itself. An end-of-interrupt that clears the wrong level becomes visible when a request of the level it should have released stays blocked. The bench follows every cycle with a reference model, so any such divergence is reported within one cycle of the edge that caused it.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N  = 8,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic          ack,
  input  logic          sel,
  input  logic          rd,
  input  logic          wr,
  input  logic          addr,
  input  logic [VW-1:0] wdata,
  output logic [VW-1:0] rdata,
  output logic          int_out
);
  localparam int IW = $clog2(N);
  localparam int BW = VW - IW;

  logic [N-1:0]  irr, isr, mask, prev;
  logic [BW-1:0] base;
  logic [IW-1:0] win_idx;

  wire [N-1:0] rise    = irq_in & ~prev;
  wire [N-1:0] isr_low = isr & (~isr + 1'b1);
  wire [N-1:0] allow   = (isr == '0) ? '1 : isr_low - 1'b1;
  wire [N-1:0] cand    = irr & ~mask & allow;
  wire [N-1:0] win     = cand & (~cand + 1'b1);
  wire [N-1:0] grant   = ack ? win : '0;
  wire         wr0     = sel & wr & ~addr;
  wire         eoi     = wr0 & wdata[0];
  wire         base_wr = wr0 & ~wdata[0];
  wire         mask_wr = sel & wr & addr;

  always_comb begin
    win_idx = IW'(N - 1);
    for (int i = N - 1; i >= 0; i--)
      if (win[i]) win_idx = IW'(i);
  end

  assign int_out = |cand;
  assign rdata   = ack ? {base, win_idx} : (sel & rd & addr) ? VW'(mask) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr  <= '0;
      isr  <= '0;
      mask <= '1;
      prev <= '0;
      base <= '0;
    end else begin
      irr  <= (irr & ~grant) | rise;
      isr  <= (isr & ~(eoi ? isr_low : '0)) | grant;
      prev <= irq_in;
      if (mask_wr) mask <= wdata[N-1:0];
      if (base_wr) base <= wdata[VW-1:IW];
    end
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ack,
  input logic         sel,
  input logic         wr,
  input logic         addr,
  input logic [7:0]   wdata,
  input logic         int_out,
  input logic [N-1:0] irr,
  input logic [N-1:0] isr,
  input logic [N-1:0] mask
);
  wire eoi_cmd = sel & wr & ~addr & wdata[0];

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (mask == '1) |-> !int_out); // R2
  AST_TOP_LEVEL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) int_out |-> !isr[0]); // R5
  AST_ACK_ADDS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n) (ack && int_out && !eoi_cmd) |=> ($countones(isr) == $countones($past(isr)) + 1)); // R4
  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n) (eoi_cmd && !ack && isr != '0) |=> ($countones(isr) == $countones($past(isr)) - 1)); // R6
  AST_PENDING_STICKS: assert property (@(posedge clk) disable iff (!rst_n) !ack |=> ((irr & $past(irr)) == $past(irr))); // R7
  AST_SERVICE_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n) !ack |=> ((isr & ~$past(isr)) == '0)); // R4
endmodule

bind prio_intc prio_intc_chk #(.N(N)) chk_i (.*);

// File: tb/prio_intc_tb_top.sv
module prio_intc_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] irq_in = 0;
  logic       ack = 0, sel = 0, rd = 0, wr = 0, addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       int_out;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_irr, m_isr, m_mask, m_prev;
  logic [4:0] m_base;

  always #4 clk = ~clk;

  prio_intc dut_i (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack(ack), .sel(sel), .rd(rd),
                   .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata), .int_out(int_out));

  function automatic logic [7:0] lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return 8'(1) << i;
    return 8'h00;
  endfunction

  function automatic logic [7:0] eligible();
    logic [7:0] allow;
    allow = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (m_isr[i]) break;
      allow[i] = 1'b1;
    end
    return m_irr & ~m_mask & allow;
  endfunction

  function automatic logic [7:0] exp_vector();
    logic [7:0] e;
    e = eligible();
    for (int i = 0; i < 8; i++) if (e[i]) return {m_base, 3'(i)};
    return {m_base, 3'd7};
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [7:0] irq, input logic a, input logic s,
                      input logic r, input logic w, input logic ad, input logic [7:0] wd);
    logic [7:0] g;
    @(negedge clk);
    irq_in = irq; ack = a; sel = s; rd = r; wr = w; addr = ad; wdata = wd;
    #1;
    check(tag, "int_out", {7'd0, int_out}, {7'd0, |eligible()});
    if (a)                check(tag, "vector", rdata, exp_vector());
    else if (s && r && ad) check(tag, "mask read", rdata, m_mask);
    else                  check(tag, "idle rdata", rdata, 8'h00);
    @(posedge clk);
    g = a ? lowest(eligible()) : 8'h00;
    if (s && w && !ad && wd[0]) m_isr = m_isr & ~lowest(m_isr);
    m_isr = m_isr | g;
    m_irr = (m_irr & ~g) | (irq & ~m_prev);
    m_prev = irq;
    if (s && w && ad) m_mask = wd;
    if (s && w && !ad && !wd[0]) m_base = wd[7:3];
  endtask

  initial begin
    m_irr = 0; m_isr = 0; m_mask = 8'hFF; m_prev = 0; m_base = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    step("R1", 8'h00, 0, 1, 1, 0, 1, 8'h00);
    step("R8", 8'h00, 0, 1, 0, 1, 0, 8'hA8);
    step("R2", 8'h00, 0, 1, 0, 1, 1, 8'hFF);
    step("R2", 8'h03, 0, 0, 0, 0, 0, 8'h00);
    step("R2", 8'h03, 0, 0, 0, 0, 0, 8'h00);
    step("R2", 8'h00, 0, 1, 0, 1, 1, 8'h03);
    step("R2", 8'h00, 0, 1, 0, 1, 1, 8'h00);
    step("R3", 8'h90, 0, 0, 0, 0, 0, 8'h00);
    step("R3", 8'h90, 1, 0, 0, 0, 0, 8'h00);
    step("R3", 8'h90, 1, 0, 0, 0, 0, 8'h00);
    step("R4", 8'h90, 1, 0, 0, 0, 0, 8'h00);
    step("R5", 8'h90, 0, 0, 0, 0, 0, 8'h00);
    step("R6", 8'h90, 0, 1, 0, 1, 0, 8'h01);
    step("R6", 8'h90, 0, 1, 0, 1, 0, 8'hF9);
    step("R7", 8'h90, 1, 0, 0, 0, 0, 8'h00);
    step("R9", 8'h90, 1, 0, 0, 0, 0, 8'h00);
    step("R7", 8'h00, 0, 1, 0, 1, 0, 8'h01);
    step("R7", 8'h01, 0, 0, 0, 0, 0, 8'h00);
    step("R7", 8'h00, 0, 0, 0, 0, 0, 8'h00);
    step("R10", 8'h00, 0, 1, 1, 0, 0, 8'h00);
    step("R5", 8'h00, 1, 0, 0, 0, 0, 8'h00);
    step("R5", 8'h20, 0, 0, 0, 0, 0, 8'h00);
    step("R6", 8'h00, 0, 1, 0, 1, 0, 8'h01);
    step("R6", 8'h00, 0, 0, 0, 0, 0, 8'h00);
    void'($urandom(32'h1D5EED));
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] q;
      logic a, s, r, w, ad;
      string tg;
      q  = irq_in ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
      a  = ($urandom % 4) == 0;
      s  = ($urandom % 3) == 0;
      w  = s && (($urandom % 3) == 0);
      r  = s && !w && ($urandom % 2);
      ad = ($urandom % 3) == 0;
      tg = a ? "R4" : (s && r && ad) ? "R2" : (s && w && !ad) ? "R6" : "R10";
      step(tg, q, a, s, r, w, ad, 8'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule